// File: doc/BRIEF.md
# Serial Character Transmitter with Queued Break and Idle

This block serialises characters onto an asynchronous line. Software-style writes place a character in a one-entry holding buffer. When a baud tick arrives and the shift register is free, the buffer moves into the shift register, which sends a low start bit, the data least-significant bit first, and a high stop bit. Each bit lasts one baud tick.

Two control-bit edges queue special characters. A rising edge on the break control queues a break character: a whole frame time of logic 0, including the stop position. If the break control is still set when that break enters the shift register, a further break is queued. A rising edge on the enable queues an idle character: a whole frame time of logic 1. When the shift register frees up, queued work is taken in a fixed order: data, then break, then idle.

Clearing the enable does not release the line straight away. The block keeps its output enable asserted until the shift register and every queue are empty. A disable followed quickly by a re-enable therefore never lets go of the line.

Top module: `async_tx`

## Requirements
- R1: After reset, tx_line is 1, tx_oe is 0, buf_empty is 1 and tx_done is 1.
- R2: A data frame is a 0 start bit, then the data bits least-significant first, then a 1 stop bit. With ctl_long=0 it is 10 bit times and uses data_in[7:0]. With ctl_long=1 it is 11 bit times and uses data_in[8:0].
- R3: tx_line changes only on a clock edge at which baud_tick is 1. Each bit is held for exactly one tick period. A pending character starts on the first tick after it becomes pending, or back to back on the tick that ends the previous frame.
- R4: A data write while enabled clears buf_empty. buf_empty is set again on the tick that moves the character into the shift register.
- R5: tx_done is set in the edge that ends a stop-bit period when nothing is pending. It is cleared by an accepted data write or by queuing a break or idle character. While it is 1 the shift register is idle.
- R6: A 0-to-1 write of ctl_brk queues one break character: a full frame time of 0, with the stop position also 0.
- R7: If ctl_brk is still 1 when a queued break is loaded into the shift register, one more break is queued right behind it.
- R8: A 0-to-1 write of ctl_en queues one idle character, which is a full frame time of 1.
- R9: When the shift register frees up, a buffered data character goes first, then a queued break, then a queued idle character.
- R10: After ctl_en is written 0, tx_oe stays 1 until the shift register and all queues are empty. It falls on the next clock edge after that. While tx_oe is 0, tx_line is 1.
- R11: A data write while the enable is 0 is ignored: buf_empty stays 1 and no frame is sent.
- R12: Writing ctl_en 0 and then 1 while a frame is in flight keeps tx_oe at 1 without a break. The idle character follows that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| ctl_wr | input | 1 | Write strobe for the control fields |
| ctl_en | input | 1 | Transmit enable value |
| ctl_brk | input | 1 | Send-break control value |
| ctl_long | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| data_wr | input | 1 | Write strobe for the holding buffer |
| data_in | input | DATA_W | Character to transmit |
| tx_line | output | 1 | Serial output, registered |
| tx_oe | output | 1 | High while the block owns the line |
| buf_empty | output | 1 | Holding buffer may be written |
| tx_done | output | 1 | Line idle, nothing in flight or queued |

## Verification
The hardest state to reach is a shift register that is busy while all three queues hold work and the enable has just been cycled. That is the only place where the priority order and the deferred release can be seen together. The stimulus starts one data frame and refills the buffer right after the first tick. It then pulses the break control and cycles the enable while that frame is still on the line. The bench then traces 40 bit periods and checks the order data, data, zeros, ones, with tx_done set only after the last one. A second scenario holds the break control across a load, so the re-queue yields exactly twenty low bit times.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;
  // what the shift register is told to take on a free tick
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_DATA  = 2'd1,
    LD_BREAK = 2'd2,
    LD_IDLE  = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/async_tx_shift.sv
`timescale 1ns/1ps
module async_tx_shift #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               long_mode,
  output logic               accept,
  output logic               finish,
  output logic               busy,
  output logic               line
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(FRAME_W - 2);

  logic [FRAME_W-1:0] sr_q;
  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      last_q;
  logic               busy_q;

  assign finish = tick && busy_q && (cnt_q == last_q);
  assign accept = tick && (!busy_q || (cnt_q == last_q));
  assign busy   = busy_q;
  assign line   = sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      last_q <= LAST_SHORT;
      busy_q <= 1'b0;
    end else if (load) begin
      sr_q   <= frame;
      cnt_q  <= '0;
      last_q <= long_mode ? LAST_LONG : LAST_SHORT;
      busy_q <= 1'b1;
    end else if (finish) begin
      sr_q   <= '1;
      busy_q <= 1'b0;
    end else if (tick && busy_q) begin
      sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/async_tx_ctrl.sv
`timescale 1ns/1ps
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr,
  input  logic               ctl_en,
  input  logic               ctl_brk,
  input  logic               ctl_long,
  input  logic               data_wr,
  input  logic [DATA_W-1:0]  data_in,
  input  logic               sh_accept,
  input  logic               sh_finish,
  input  logic               sh_busy,
  output logic               ld,
  output logic [FRAME_W-1:0] ld_frame,
  output logic               ld_long,
  output logic               buf_empty,
  output logic               tx_done,
  output logic               tx_oe
);
  logic              en_q, brk_q, long_q;
  logic              empty_q, bpend_q, ipend_q;
  logic              done_q, oe_q;
  logic [DATA_W-1:0] buf_q;
  logic [FRAME_W-1:0] data_frame;
  ld_kind_e          kind;

  logic rise_en, rise_brk, data_acc;
  assign rise_en  = ctl_wr && ctl_en && !en_q;
  assign rise_brk = ctl_wr && ctl_brk && !brk_q;
  assign data_acc = data_wr && en_q;

  // fixed order on a free tick: data, break, idle
  always_comb begin
    kind = LD_NONE;
    if (sh_accept) begin
      if (!empty_q)     kind = LD_DATA;
      else if (bpend_q) kind = LD_BREAK;
      else if (ipend_q) kind = LD_IDLE;
    end
  end

  always_comb begin
    data_frame    = '1;
    data_frame[0] = 1'b0;
    if (long_q) data_frame[DATA_W:1]   = buf_q;
    else        data_frame[DATA_W-1:1] = buf_q[DATA_W-2:0];
  end

  always_comb begin
    case (kind)
      LD_DATA:  ld_frame = data_frame;
      LD_BREAK: ld_frame = '0;
      default:  ld_frame = '1;
    endcase
  end

  assign ld        = (kind != LD_NONE);
  assign ld_long   = long_q;
  assign buf_empty = empty_q;
  assign tx_done   = done_q;
  assign tx_oe     = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      brk_q   <= 1'b0;
      long_q  <= 1'b0;
      empty_q <= 1'b1;
      bpend_q <= 1'b0;
      ipend_q <= 1'b0;
      done_q  <= 1'b1;
      oe_q    <= 1'b0;
      buf_q   <= '0;
    end else begin
      if (ctl_wr) begin
        en_q   <= ctl_en;
        brk_q  <= ctl_brk;
        long_q <= ctl_long;
      end
      if (data_acc) begin
        buf_q   <= data_in;
        empty_q <= 1'b0;
      end else if (kind == LD_DATA) begin
        empty_q <= 1'b1;
      end
      if (rise_brk)               bpend_q <= 1'b1;
      else if (kind == LD_BREAK)  bpend_q <= brk_q;
      if (rise_en)                ipend_q <= 1'b1;
      else if (kind == LD_IDLE)   ipend_q <= 1'b0;
      if (data_acc || rise_brk || rise_en)     done_q <= 1'b0;
      else if (sh_finish && kind == LD_NONE)   done_q <= 1'b1;
      oe_q <= en_q || sh_busy || !empty_q || bpend_q || ipend_q;
    end
  end
endmodule

// File: rtl/async_tx.sv
`timescale 1ns/1ps
module async_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              ctl_brk,
  input  logic              ctl_long,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FRAME_W = DATA_W + 2;

  logic               sh_accept, sh_finish, sh_busy;
  logic               ld, ld_long;
  logic [FRAME_W-1:0] ld_frame;

  async_tx_ctrl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_brk(ctl_brk), .ctl_long(ctl_long),
    .data_wr(data_wr), .data_in(data_in),
    .sh_accept(sh_accept), .sh_finish(sh_finish), .sh_busy(sh_busy),
    .ld(ld), .ld_frame(ld_frame), .ld_long(ld_long),
    .buf_empty(buf_empty), .tx_done(tx_done), .tx_oe(tx_oe)
  );

  async_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick),
    .load(ld), .frame(ld_frame), .long_mode(ld_long),
    .accept(sh_accept), .finish(sh_finish), .busy(sh_busy), .line(tx_line)
  );
endmodule

// File: rtl/async_tx_chk.sv
`timescale 1ns/1ps
module async_tx_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic tx_line,
  input logic tx_oe,
  input logic buf_empty,
  input logic tx_done,
  input logic sh_busy
);
  p_released_high_r10: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> tx_line);
  p_shifter_owns_r10: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> tx_oe);
  p_oe_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_oe) |-> !$past(sh_busy));
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(tx_line));
  p_empty_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> $past(baud_tick));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !sh_busy);
endmodule

bind async_tx async_tx_chk u_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_line(tx_line),
  .tx_oe(tx_oe), .buf_empty(buf_empty), .tx_done(tx_done), .sh_busy(sh_busy)
);

// File: tb/tb_async_tx.sv
`timescale 1ns/1ps
module tb_async_tx;
  localparam int DATA_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic ctl_wr = 1'b0, ctl_en = 1'b0, ctl_brk = 1'b0, ctl_long = 1'b0;
  logic data_wr = 1'b0;
  logic [DATA_W-1:0] data_in = '0;
  logic tx_line, tx_oe, buf_empty, tx_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic trace [0:63];
  logic oetr  [0:63];
  logic expb  [0:63];
  int   n_exp = 0;

  async_tx #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_brk(ctl_brk), .ctl_long(ctl_long),
    .data_wr(data_wr), .data_in(data_in),
    .tx_line(tx_line), .tx_oe(tx_oe), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #2.5 clk = ~clk;

  // one tick every 8 clocks, driven 1 ns after the edge
  initial begin
    forever begin
      repeat (7) @(posedge clk);
      #1 baud_tick = 1'b1;
      @(posedge clk);
      #1 baud_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick();
    while (baud_tick !== 1'b1) @(negedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic record(input int from, input int n);
    for (int i = 0; i < n; i++) begin
      next_tick();
      trace[from+i] = tx_line;
      oetr[from+i]  = tx_oe;
    end
  endtask

  task automatic ctl(input logic en, input logic brk, input logic lng);
    @(negedge clk);
    ctl_en = en; ctl_brk = brk; ctl_long = lng; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wdata(input logic [DATA_W-1:0] v);
    @(negedge clk);
    data_in = v; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic push_bit(input logic b);
    expb[n_exp] = b;
    n_exp++;
  endtask

  task automatic push_frame(input logic [DATA_W-1:0] v, input bit lng);
    push_bit(1'b0);
    for (int i = 0; i < (lng ? 9 : 8); i++) push_bit(v[i]);
    push_bit(1'b1);
  endtask

  task automatic push_const(input logic b, input int n);
    for (int i = 0; i < n; i++) push_bit(b);
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n_exp; i++) begin
      if (trace[i] !== expb[i]) begin
        if (bad == 0)
          $display("FAIL %s: bit %0d actual %0d expected %0d", req, i, trace[i], expb[i]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
    n_exp = 0;
  endtask

  task automatic t_reset();
    chk("R1 line", tx_line, 1);
    chk("R1 oe", tx_oe, 0);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 done", tx_done, 1);
  endtask

  task automatic t_enable_idle();
    ctl(1, 0, 0);
    record(0, 10);
    push_const(1'b1, 10);
    compare("R8 idle char ones");
    chk("R5 done low during idle char", tx_done, 0);
    next_tick();
    chk("R5 done after idle char", tx_done, 1);
    chk("R8 oe held while enabled", tx_oe, 1);
  endtask

  task automatic t_data8();
    wdata(9'h1A5);
    chk("R4 buf_empty cleared by write", buf_empty, 0);
    chk("R5 done cleared by write", tx_done, 0);
    record(0, 10);
    push_frame(9'h0A5, 0);
    compare("R2 8-bit frame");
    chk("R4 buf_empty set on load", buf_empty, 1);
    next_tick();
    chk("R5 done after stop", tx_done, 1);
    chk("R3 line idle after stop", tx_line, 1);
  endtask

  task automatic t_data9();
    ctl(1, 0, 1);
    wdata(9'h13C);
    record(0, 11);
    push_frame(9'h13C, 1);
    compare("R2 9-bit frame");
    next_tick();
    chk("R5 done after 9-bit frame", tx_done, 1);
    ctl(1, 0, 0);
  endtask

  task automatic t_b2b();
    wdata(9'h0C3);
    record(0, 1);
    chk("R4 buf_empty after first tick", buf_empty, 1);
    wdata(9'h05A);
    chk("R4 buf_empty cleared again", buf_empty, 0);
    record(1, 19);
    push_frame(9'h0C3, 0);
    push_frame(9'h05A, 0);
    compare("R3 back-to-back frames");
    next_tick();
    chk("R5 done after pair", tx_done, 1);
  endtask

  task automatic t_break();
    ctl(1, 1, 0);
    ctl(1, 0, 0);
    record(0, 11);
    push_const(1'b0, 10);
    push_const(1'b1, 1);
    compare("R6 single break");
    chk("R5 done after break", tx_done, 1);
  endtask

  task automatic t_break_hold();
    ctl(1, 1, 0);
    record(0, 5);
    ctl(1, 0, 0);
    record(5, 16);
    push_const(1'b0, 20);
    push_const(1'b1, 1);
    compare("R7 held break re-queues once");
  endtask

  task automatic t_priority();
    wdata(9'h0F0);
    record(0, 1);
    wdata(9'h00F);
    ctl(1, 1, 0);
    ctl(1, 0, 0);
    record(1, 1);
    ctl(0, 0, 0);
    ctl(1, 0, 0);
    record(2, 38);
    push_frame(9'h0F0, 0);
    push_frame(9'h00F, 0);
    push_const(1'b0, 10);
    push_const(1'b1, 10);
    compare("R9 data then break then idle");
    chk("R9 idle still running", tx_done, 0);
    next_tick();
    chk("R9 done after idle", tx_done, 1);
  endtask

  task automatic t_disable();
    int oe_low;
    wdata(9'h033);
    record(0, 1);
    ctl(0, 0, 0);
    record(1, 9);
    push_frame(9'h033, 0);
    compare("R10 frame completes after disable");
    oe_low = 0;
    for (int i = 0; i < 10; i++) if (oetr[i] !== 1'b1) oe_low++;
    chk("R10 oe held during frame", oe_low, 0);
    next_tick();
    chk("R10 oe at finishing tick", tx_oe, 1);
    @(posedge clk); #2;
    chk("R10 oe released", tx_oe, 0);
    chk("R10 line high when released", tx_line, 1);
    wdata(9'h055);
    chk("R11 write ignored when disabled", buf_empty, 1);
    record(0, 12);
    oe_low = 0;
    for (int i = 0; i < 12; i++) if (trace[i] !== 1'b1 || oetr[i] !== 1'b0) oe_low++;
    chk("R11 no frame sent when disabled", oe_low, 0);
    ctl(1, 0, 0);
    record(0, 11);
  endtask

  task automatic t_toggle();
    int oe_low;
    wdata(9'h096);
    record(0, 1);
    ctl(0, 0, 0);
    ctl(1, 0, 0);
    record(1, 19);
    push_frame(9'h096, 0);
    push_const(1'b1, 10);
    compare("R12 frame then idle after toggle");
    oe_low = 0;
    for (int i = 0; i < 20; i++) if (oetr[i] !== 1'b1) oe_low++;
    chk("R12 oe never dropped", oe_low, 0);
    next_tick();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    t_reset();
    t_enable_idle();
    t_data8();
    t_data9();
    t_b2b();
    t_break();
    t_break_hold();
    t_priority();
    t_disable();
    t_toggle();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule